// File: doc/BRIEF.md
# Low-Power Sequencing Controller

This block is a management-side state machine that starts a companion user processor and then moves the chip between its full-power and lowest-power clock settings. When the system reset is released, it works through a fixed boot order. It first programs the clock generator and DLL for full speed. It then strobes the pad-routing configuration. Next it raises the user-clock full-speed enable, and last it releases the user-logic reset.

While it waits for the user core to report that it is healthy, the external clock generator stays powered. When the user core sends a running-OK message, the controller switches the external clock generator off. If no such message arrives within a bounded time, the controller flags a boot error and leaves the generator on.

After boot, the user core asks for the low-power or full-power setting by writing a mailbox message and raising the interrupt line. A wake-up from the real-time clock reaches this block as a full-power request. Every clock/DLL reprogramming is followed by a lock-settle wait. Only after that wait does the controller answer the user core through its mailbox reply.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `user_rst_n`=0, `ext_cpg_pwr_en`=1, `uclk_fast_en`=0, `boot_err`=0, `clk_cmd_low`=0, and no strobe (`clk_cmd_valid`, `pad_cfg_stb`, `mbox_reply_vld`) is high.
- R2: After reset release, exactly one clock command with `clk_cmd_low`=0 is issued first. `pad_cfg_stb` pulses at least SETTLE_CYC cycles after that command. `uclk_fast_en` rises in a later cycle than the pad strobe.
- R3: `user_rst_n` rises in a later cycle than `uclk_fast_en`, and it is never high while `uclk_fast_en` is low.
- R4: A mailbox write with code 01 (running-OK), received while waiting after user reset release, turns `ext_cpg_pwr_en` off. It issues no clock command, and the generator power stays off until the next system reset.
- R5: If no running-OK arrives within BOOT_TIMEOUT cycles of user reset release, `boot_err` goes to 1 no earlier than that count and `ext_cpg_pwr_en` stays 1. A running-OK that arrives later is ignored.
- R6: At full power, a write with code 10 (go-low) and `mbox_irq` high issues one clock command with `clk_cmd_low`=1. It is followed at least SETTLE_CYC cycles later by a reply with code 10.
- R7: At low power, a write with code 11 (go-full) and `mbox_irq` high issues one clock command with `clk_cmd_low`=0. It is followed at least SETTLE_CYC cycles later by a reply with code 11 ("went full power").
- R8: A go-low while already low, or a go-full while already at full power, issues no clock command. It produces a reply (10 or 11, matching the current setting) within four cycles.
- R9: The following are ignored: code 00, code 01 after boot, go-low or go-full without `mbox_irq`, and any request during boot or during a settle wait. Ignored messages produce no command and no reply, and they leave `clk_cmd_low` unchanged.
- R10: A system reset asserted at any point, including in low power, returns all outputs to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock supplied by the harness |
| rst_n | input | 1 | Synchronous active-low system reset |
| mbox_wr | input | 1 | Mailbox write strobe from the user core |
| mbox_code | input | 2 | Message code: 00 idle, 01 running-OK, 10 go-low, 11 go-full |
| mbox_irq | input | 1 | Interrupt line accompanying power requests |
| clk_cmd_valid | output | 1 | One-cycle clock/DLL reprogramming command |
| clk_cmd_low | output | 1 | Setting commanded: 1 lowest power, 0 full power |
| pad_cfg_stb | output | 1 | One-cycle pad routing / GPIO configuration strobe |
| uclk_fast_en | output | 1 | User clock full-speed enable |
| user_rst_n | output | 1 | Active-low reset to the user logic |
| ext_cpg_pwr_en | output | 1 | Power enable for the external clock generator |
| boot_err | output | 1 | Running-OK never arrived within the timeout |
| mbox_reply_vld | output | 1 | One-cycle mailbox reply strobe |
| mbox_reply_code | output | 2 | Reply: 10 now low power, 11 now full power |

## Verification
A corrupted state register would appear at the ports within one settle window. It would show up as a clock command with the wrong `clk_cmd_low` level, a reply whose code disagrees with the programmed setting, or a reply that arrives sooner than SETTLE_CYC after its command. A wrong boot step would break the strict cycle order of command, pad strobe, clock enable and reset release, which is visible within about twenty cycles of reset release. Mis-decoded or badly gated mailbox messages show up within four cycles, as an unexpected command or reply or as a missing one.

// File: rtl/lpm_pkg.sv
// Package: shared state encoding and mailbox code values for the
// low-power sequencing controller. Assumes 2-bit mailbox codes.
package lpm_pkg;

    typedef enum logic [3:0] {
        ST_BOOT_CLK,
        ST_BOOT_SETTLE,
        ST_BOOT_PAD,
        ST_BOOT_UCLK,
        ST_BOOT_URST,
        ST_WAIT_OK,
        ST_RUN_FULL,
        ST_GO_LOW,
        ST_SETTLE_LOW,
        ST_RUN_LOW,
        ST_GO_FULL,
        ST_SETTLE_FULL
    } lpm_state_e;

    localparam int          MSG_W       = 2;
    localparam logic [1:0]  MSG_IDLE    = 2'b00;
    localparam logic [1:0]  MSG_RUN_OK  = 2'b01;
    localparam logic [1:0]  MSG_GO_LOW  = 2'b10;
    localparam logic [1:0]  MSG_GO_FULL = 2'b11;

    localparam logic [1:0]  RPL_NOW_LOW  = 2'b10;
    localparam logic [1:0]  RPL_NOW_FULL = 2'b11;

endpackage

// File: rtl/lpm_cycle_timer.sv
// Module: one-shot down-counter. An arm pulse loads LEN. The fire output
// pulses for one cycle when the count reaches zero. Assumes LEN >= 1.
// Re-arming while counting restarts the window.
module lpm_cycle_timer #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic fire
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LOAD = CW'(LEN);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt;

    // Count down from LEN after arm and pulse fire on the final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            fire <= 1'b0;
        end else if (arm) begin
            cnt  <= LOAD;
            fire <= 1'b0;
        end else if (cnt != '0) begin
            cnt  <= cnt - ONE;
            fire <= (cnt == ONE);
        end else begin
            fire <= 1'b0;
        end
    end

    AST_FIRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);  // R2
endmodule

// File: rtl/lpm_mbox_rx.sv
// Module: mailbox receiver. Turns a write strobe plus code into one-cycle
// request pulses, one register stage late. Power requests need the
// interrupt line high in the same cycle as the write. Running-OK does not.
module lpm_mbox_rx
    import lpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mbox_wr,
    input  logic [MSG_W-1:0] mbox_code,
    input  logic             mbox_irq,
    output logic             req_ok,
    output logic             req_low,
    output logic             req_full
);
    // Register decoded request pulses; idle and unqualified codes give none.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_ok   <= 1'b0;
            req_low  <= 1'b0;
            req_full <= 1'b0;
        end else begin
            req_ok   <= mbox_wr && (mbox_code == MSG_RUN_OK);
            req_low  <= mbox_wr && mbox_irq && (mbox_code == MSG_GO_LOW);
            req_full <= mbox_wr && mbox_irq && (mbox_code == MSG_GO_FULL);
        end
    end

    AST_REQ_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_low || req_full) |-> $past(mbox_wr && mbox_irq));  // R9
endmodule

// File: rtl/lpm_seq_ctrl.sv
// Module: top of the low-power sequencing controller. Runs the fixed boot
// order, drops external clock-generator power on running-OK (or flags a
// timeout), then serves go-low / go-full requests, each reprogramming
// followed by a lock-settle wait and a reply. All outputs are registered.
// Assumes a synchronous active-low reset that the harness holds at power-up.
module lpm_seq_ctrl
    import lpm_pkg::*;
#(
    parameter int SETTLE_CYC   = 16,
    parameter int BOOT_TIMEOUT = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mbox_wr,
    input  logic [MSG_W-1:0] mbox_code,
    input  logic             mbox_irq,
    output logic             clk_cmd_valid,
    output logic             clk_cmd_low,
    output logic             pad_cfg_stb,
    output logic             uclk_fast_en,
    output logic             user_rst_n,
    output logic             ext_cpg_pwr_en,
    output logic             boot_err,
    output logic             mbox_reply_vld,
    output logic [MSG_W-1:0] mbox_reply_code
);
    lpm_state_e state;
    logic       req_ok, req_low, req_full;
    logic       settle_arm, settle_fire;
    logic       boot_arm, boot_fire;

    lpm_mbox_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .mbox_wr   (mbox_wr),
        .mbox_code (mbox_code),
        .mbox_irq  (mbox_irq),
        .req_ok    (req_ok),
        .req_low   (req_low),
        .req_full  (req_full)
    );

    // Arm the settle timer in every state that issues a clock command.
    always_comb begin
        settle_arm = (state == ST_BOOT_CLK) || (state == ST_GO_LOW) ||
                     (state == ST_GO_FULL);
        boot_arm   = (state == ST_BOOT_URST);
    end

    lpm_cycle_timer #(.LEN(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (settle_arm),
        .fire  (settle_fire)
    );

    lpm_cycle_timer #(.LEN(BOOT_TIMEOUT)) u_boot_to (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (boot_arm),
        .fire  (boot_fire)
    );

    // Sequence state and registered outputs; strobes default low each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state           <= ST_BOOT_CLK;
            clk_cmd_valid   <= 1'b0;
            clk_cmd_low     <= 1'b0;
            pad_cfg_stb     <= 1'b0;
            uclk_fast_en    <= 1'b0;
            user_rst_n      <= 1'b0;
            ext_cpg_pwr_en  <= 1'b1;
            boot_err        <= 1'b0;
            mbox_reply_vld  <= 1'b0;
            mbox_reply_code <= RPL_NOW_FULL;
        end else begin
            clk_cmd_valid  <= 1'b0;
            pad_cfg_stb    <= 1'b0;
            mbox_reply_vld <= 1'b0;
            unique case (state)
                ST_BOOT_CLK: begin
                    clk_cmd_valid <= 1'b1;
                    clk_cmd_low   <= 1'b0;
                    state         <= ST_BOOT_SETTLE;
                end
                ST_BOOT_SETTLE: begin
                    if (settle_fire) state <= ST_BOOT_PAD;
                end
                ST_BOOT_PAD: begin
                    pad_cfg_stb <= 1'b1;
                    state       <= ST_BOOT_UCLK;
                end
                ST_BOOT_UCLK: begin
                    uclk_fast_en <= 1'b1;
                    state        <= ST_BOOT_URST;
                end
                ST_BOOT_URST: begin
                    user_rst_n <= 1'b1;
                    state      <= ST_WAIT_OK;
                end
                ST_WAIT_OK: begin
                    if (req_ok) begin
                        ext_cpg_pwr_en <= 1'b0;
                        state          <= ST_RUN_FULL;
                    end else if (boot_fire) begin
                        boot_err <= 1'b1;
                        state    <= ST_RUN_FULL;
                    end
                end
                ST_RUN_FULL: begin
                    if (req_low) begin
                        state <= ST_GO_LOW;
                    end else if (req_full) begin
                        mbox_reply_vld  <= 1'b1;
                        mbox_reply_code <= RPL_NOW_FULL;
                    end
                end
                ST_GO_LOW: begin
                    clk_cmd_valid <= 1'b1;
                    clk_cmd_low   <= 1'b1;
                    state         <= ST_SETTLE_LOW;
                end
                ST_SETTLE_LOW: begin
                    if (settle_fire) begin
                        mbox_reply_vld  <= 1'b1;
                        mbox_reply_code <= RPL_NOW_LOW;
                        state           <= ST_RUN_LOW;
                    end
                end
                ST_RUN_LOW: begin
                    if (req_full) begin
                        state <= ST_GO_FULL;
                    end else if (req_low) begin
                        mbox_reply_vld  <= 1'b1;
                        mbox_reply_code <= RPL_NOW_LOW;
                    end
                end
                ST_GO_FULL: begin
                    clk_cmd_valid <= 1'b1;
                    clk_cmd_low   <= 1'b0;
                    state         <= ST_SETTLE_FULL;
                end
                ST_SETTLE_FULL: begin
                    if (settle_fire) begin
                        mbox_reply_vld  <= 1'b1;
                        mbox_reply_code <= RPL_NOW_FULL;
                        state           <= ST_RUN_FULL;
                    end
                end
                default: state <= ST_BOOT_CLK;
            endcase
        end
    end

    AST_URST_NEEDS_UCLK: assert property (@(posedge clk) disable iff (!rst_n)
        user_rst_n |-> uclk_fast_en);  // R3
    AST_UCLK_AFTER_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uclk_fast_en) |-> $past(pad_cfg_stb));  // R2
    AST_CPG_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_cpg_pwr_en |=> !ext_cpg_pwr_en);  // R4
    AST_ERR_KEEPS_CPG: assert property (@(posedge clk) disable iff (!rst_n)
        boot_err |-> ext_cpg_pwr_en);  // R5
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clk_cmd_valid, pad_cfg_stb, mbox_reply_vld}));  // R9
    AST_REPLY_MATCHES_SETTING: assert property (@(posedge clk) disable iff (!rst_n)
        mbox_reply_vld |-> (mbox_reply_code == {1'b1, !clk_cmd_low}));  // R8
    AST_CMD_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        clk_cmd_valid |=> !clk_cmd_valid);  // R6
endmodule

// File: tb/sim_lpm_seq_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_lpm_seq_ctrl;
    localparam int SETTLE = 16;
    localparam int TOUT   = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mbox_wr = 1'b0;
    logic [1:0] mbox_code = 2'b00;
    logic       mbox_irq = 1'b0;
    logic       clk_cmd_valid, clk_cmd_low, pad_cfg_stb, uclk_fast_en;
    logic       user_rst_n, ext_cpg_pwr_en, boot_err, mbox_reply_vld;
    logic [1:0] mbox_reply_code;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_cmd = 0, n_reply = 0, n_pad = 0;
    int cmd_cyc = 0, pad_cyc = 0, reply_cyc = 0;
    int uclk_cyc = 0, urst_cyc = 0, err_cyc = 0;
    logic last_cmd_low = 1'b0;
    logic [1:0] last_reply = 2'b00;
    logic p_uclk = 1'b0, p_urst = 1'b0, p_err = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lpm_seq_ctrl #(.SETTLE_CYC(SETTLE), .BOOT_TIMEOUT(TOUT)) u0 (
        .clk(clk), .rst_n(rst_n), .mbox_wr(mbox_wr), .mbox_code(mbox_code),
        .mbox_irq(mbox_irq), .clk_cmd_valid(clk_cmd_valid),
        .clk_cmd_low(clk_cmd_low), .pad_cfg_stb(pad_cfg_stb),
        .uclk_fast_en(uclk_fast_en), .user_rst_n(user_rst_n),
        .ext_cpg_pwr_en(ext_cpg_pwr_en), .boot_err(boot_err),
        .mbox_reply_vld(mbox_reply_vld), .mbox_reply_code(mbox_reply_code)
    );

    // Event monitor sampling outputs at the falling edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (clk_cmd_valid) begin n_cmd++; cmd_cyc = cyc; last_cmd_low = clk_cmd_low; end
        if (pad_cfg_stb) begin n_pad++; pad_cyc = cyc; end
        if (mbox_reply_vld) begin n_reply++; reply_cyc = cyc; last_reply = mbox_reply_code; end
        if (uclk_fast_en && !p_uclk) uclk_cyc = cyc;
        if (user_rst_n && !p_urst) urst_cyc = cyc;
        if (boot_err && !p_err) err_cyc = cyc;
        p_uclk = uclk_fast_en; p_urst = user_rst_n; p_err = boot_err;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic send(input logic [1:0] code, input logic irq);
        @(negedge clk);
        mbox_wr = 1'b1; mbox_code = code; mbox_irq = irq;
        @(negedge clk);
        mbox_wr = 1'b0; mbox_code = 2'b00; mbox_irq = 1'b0;
        #1;
    endtask

    task automatic check_reset_values(input string req);
        chk(user_rst_n == 1'b0, req, user_rst_n, 0);
        chk(ext_cpg_pwr_en == 1'b1, req, ext_cpg_pwr_en, 1);
        chk(uclk_fast_en == 1'b0, req, uclk_fast_en, 0);
        chk(boot_err == 1'b0, req, boot_err, 0);
        chk(clk_cmd_low == 1'b0, req, clk_cmd_low, 0);
        chk({clk_cmd_valid, pad_cfg_stb, mbox_reply_vld} == 3'b000, req,
            {clk_cmd_valid, pad_cfg_stb, mbox_reply_vld}, 0);
    endtask

    // R1 and R2/R3: reset values, then the boot order.
    task automatic t_boot();
        int c0;
        rst_n = 1'b0;
        wait_cyc(3);
        check_reset_values("R1");
        c0 = n_cmd;
        @(negedge clk); rst_n = 1'b1;
        wait_cyc(40);
        chk(n_cmd - c0 == 1, "R2 one boot cmd", n_cmd - c0, 1);
        chk(last_cmd_low == 1'b0, "R2 boot cmd full", last_cmd_low, 0);
        chk(pad_cyc - cmd_cyc >= SETTLE, "R2 pad after settle", pad_cyc - cmd_cyc, SETTLE);
        chk(uclk_cyc > pad_cyc, "R2 uclk after pad", uclk_cyc, pad_cyc + 1);
        chk(urst_cyc > uclk_cyc, "R3 urst after uclk", urst_cyc, uclk_cyc + 1);
        chk(user_rst_n == 1'b1, "R3 urst released", user_rst_n, 1);
    endtask

    // R4: running-OK drops the external generator power.
    task automatic t_running_ok();
        int c0;
        c0 = n_cmd;
        chk(ext_cpg_pwr_en == 1'b1, "R4 powered before ok", ext_cpg_pwr_en, 1);
        send(2'b01, 1'b0);
        wait_cyc(3);
        chk(ext_cpg_pwr_en == 1'b0, "R4 cpg off", ext_cpg_pwr_en, 0);
        chk(n_cmd == c0, "R4 no clock cmd", n_cmd - c0, 0);
        chk(boot_err == 1'b0, "R4 no error", boot_err, 0);
    endtask

    // R6: go-low at full power.
    task automatic t_go_low();
        int c0, r0;
        c0 = n_cmd; r0 = n_reply;
        send(2'b10, 1'b1);
        wait_cyc(SETTLE + 8);
        chk(n_cmd - c0 == 1, "R6 one cmd", n_cmd - c0, 1);
        chk(last_cmd_low == 1'b1, "R6 cmd low", last_cmd_low, 1);
        chk(n_reply - r0 == 1, "R6 one reply", n_reply - r0, 1);
        chk(last_reply == 2'b10, "R6 reply code", last_reply, 2);
        chk(reply_cyc - cmd_cyc >= SETTLE, "R6 reply after settle", reply_cyc - cmd_cyc, SETTLE);
    endtask

    // R8: a repeated request answers without a clock command.
    task automatic t_repeat(input logic [1:0] code, input string req);
        int c0, r0, s0;
        c0 = n_cmd; r0 = n_reply; s0 = cyc;
        send(code, 1'b1);
        wait_cyc(4);
        chk(n_cmd == c0, req, n_cmd - c0, 0);
        chk(n_reply - r0 == 1, req, n_reply - r0, 1);
        chk(last_reply == code, req, last_reply, code);
        chk(reply_cyc - s0 <= 5, req, reply_cyc - s0, 5);
    endtask

    // R9: illegal messages while low are ignored.
    task automatic t_ignored_low();
        int c0, r0;
        c0 = n_cmd; r0 = n_reply;
        send(2'b00, 1'b1);
        send(2'b01, 1'b1);
        send(2'b11, 1'b0);
        send(2'b10, 1'b0);
        wait_cyc(4);
        chk(n_cmd == c0, "R9 no cmd", n_cmd - c0, 0);
        chk(n_reply == r0, "R9 no reply", n_reply - r0, 0);
        chk(clk_cmd_low == 1'b1, "R9 still low", clk_cmd_low, 1);
        chk(ext_cpg_pwr_en == 1'b0, "R9 cpg unchanged", ext_cpg_pwr_en, 0);
    endtask

    // R7 with R9: go-full, then a go-low during the settle is dropped.
    task automatic t_go_full_busy();
        int c0, r0;
        c0 = n_cmd; r0 = n_reply;
        send(2'b11, 1'b1);
        send(2'b10, 1'b1);
        wait_cyc(SETTLE + 8);
        chk(n_cmd - c0 == 1, "R7 one cmd", n_cmd - c0, 1);
        chk(last_cmd_low == 1'b0, "R7 cmd full", last_cmd_low, 0);
        chk(n_reply - r0 == 1, "R7 one reply", n_reply - r0, 1);
        chk(last_reply == 2'b11, "R7 went-full code", last_reply, 3);
        chk(reply_cyc - cmd_cyc >= SETTLE, "R7 reply after settle", reply_cyc - cmd_cyc, SETTLE);
        chk(clk_cmd_low == 1'b0, "R9 busy request dropped", clk_cmd_low, 0);
    endtask

    // R5: no running-OK leads to an error; the generator stays powered.
    task automatic t_timeout();
        int r0;
        rst_n = 1'b0;
        wait_cyc(3);
        @(negedge clk); rst_n = 1'b1;
        send(2'b10, 1'b1);
        wait_cyc(30);
        chk(clk_cmd_low == 1'b0, "R9 boot request dropped", clk_cmd_low, 0);
        chk(boot_err == 1'b0, "R5 no early error", boot_err, 0);
        wait_cyc(TOUT + 10);
        chk(boot_err == 1'b1, "R5 error set", boot_err, 1);
        chk(err_cyc - urst_cyc >= TOUT, "R5 not before timeout", err_cyc - urst_cyc, TOUT);
        chk(ext_cpg_pwr_en == 1'b1, "R5 cpg kept on", ext_cpg_pwr_en, 1);
        r0 = n_reply;
        send(2'b01, 1'b0);
        wait_cyc(4);
        chk(ext_cpg_pwr_en == 1'b1, "R5 late ok ignored", ext_cpg_pwr_en, 1);
        chk(n_reply == r0, "R5 late ok no reply", n_reply - r0, 0);
    endtask

    // R10: reset from low power restores the reset values.
    task automatic t_mid_reset();
        @(negedge clk); rst_n = 1'b0;
        wait_cyc(2);
        check_reset_values("R10");
        @(negedge clk); rst_n = 1'b1;
        #1;
        check_reset_values("R10 first cycle");
        wait_cyc(2);
    endtask

    initial begin
        t_boot();
        t_running_ok();
        t_repeat(2'b11, "R8 full while full");
        t_go_low();
        t_repeat(2'b10, "R8 low while low");
        t_ignored_low();
        t_go_full_busy();
        send(2'b10, 1'b1);
        wait_cyc(SETTLE + 8);
        t_mid_reset();
        t_timeout();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule